// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 SDRAM from power-up to an operational state without software help. After reset is released, or after a start pulse while it is idle, it keeps the clock-enable pin low for a programmable stabilisation time. It then raises clock-enable and drives a fixed series of precharge, mode-register, extended-mode-register and refresh commands onto a chip-select/RAS/CAS/WE command bus. The series includes DLL reset toggling and an on-die-driver calibration default/exit pair. Each command is followed by a programmable number of idle cycles, and each refresh by a longer one. When the series is complete the block raises a done flag and leaves the bus idle with clock-enable high.

The mode-register words come from configuration inputs. The block forces the bits that the sequence owns: DLL reset in the mode register, and DLL enable and the calibration field in the first extended register. A separate combinational output gives the system-address bit at which the bank field begins. The host address decoder uses it, and it depends on the column and row field settings, the decode mode and the bus width.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset is asserted, and for WAIT_CYC cycles after its release or after an accepted start, cke is 0, busy is 1, done is 0 and the bus carries NOP. NOP is {cs_n,ras_n,cas_n,we_n}=0111 with ba and addr zero.
- R2: After that wait, cke is 1 and NOP is held for GAP_CYC cycles before the first command.
- R3: Exactly 11 commands follow, in this order: precharge-all, EMRS2, EMRS3, EMRS1, MRS with DLL reset, precharge-all, refresh, refresh, MRS without DLL reset, EMRS1 with calibration default, EMRS1 with calibration exit.
- R4: The pin codes for {cs_n,ras_n,cas_n,we_n} are: precharge-all 0010 with addr bit 10 set, ba 0 and all other addr bits 0; mode or extended-mode set 0000; refresh 0001 with ba and addr 0.
- R5: EMRS2 drives ba=2 with addr=cfg_emr2. EMRS3 drives ba=3 with addr all zero. Every EMRS1 drives ba=1. Both MRS drive ba=0.
- R6: Both MRS cycles drive cfg_mr with addr bit 8 (DLL reset) forced to 1 on the first and to 0 on the second. All other bits are equal to cfg_mr.
- R7: Every EMRS1 drives cfg_emr1 with bit 0 forced to 0 (DLL enabled). Bits 9:7 are 111 on the calibration-default cycle and 000 on the other two.
- R8: Each command lasts exactly one cycle. It is followed by GAP_CYC NOP cycles, or by RFC_CYC NOP cycles after a refresh.
- R9: After the last gap, done is 1, busy is 0, cke is 1 and the bus carries NOP. This holds until a start is accepted.
- R10: A start while busy has no effect on the bus. A start while done restarts the whole series at R1.
- R11: bank_bit_pos = cfg_col + 9 + (cfg_interleave ? 0 : cfg_row + 11) + (cfg_narrow ? 1 : 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a new initialization, honoured only when done |
| cfg_col | input | COL_W | Column field setting |
| cfg_row | input | ROW_W | Row field setting |
| cfg_interleave | input | 1 | 1 = interleaved bank decode |
| cfg_narrow | input | 1 | 1 = narrow data bus |
| cfg_mr | input | ADDR_W | Mode register word |
| cfg_emr1 | input | ADDR_W | Extended mode register 1 word |
| cfg_emr2 | input | ADDR_W | Extended mode register 2 word |
| dram_cke | output | 1 | Clock enable |
| dram_cs_n | output | 1 | Chip select, active low |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_ba | output | BA_W | Bank address |
| dram_addr | output | ADDR_W | Address |
| bank_bit_pos | output | POS_W | System-address bit where the bank field starts |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete |

## Verification
The checker relies on GAP_CYC and RFC_CYC being at least one, so that every command is followed by an idle cycle. It also relies on start arriving as a synchronous level that the block may ignore. The configuration words are assumed stable during a run, because the bus copies them in the command cycle. The bench changes them only while done is high, before it issues a start. It pulses start in the middle of a run to show that the pulse is ignored.

// File: rtl/ddr2i_pkg.sv
package ddr2i_pkg;
  typedef enum logic [1:0] {K_NOP, K_PALL, K_MRS, K_REF} cmd_kind_e;
  typedef enum logic [2:0] {ST_PWR, ST_CKE, ST_CMD, ST_GAP, ST_DONE} seq_state_e;
  localparam int unsigned N_STEPS     = 11;
  localparam int unsigned STEP_W      = 4;
  localparam int unsigned DLL_RST_BIT = 8;
  localparam int unsigned DLL_DIS_BIT = 0;
  localparam int unsigned OCD_LSB     = 7;
  localparam int unsigned OCD_W       = 3;
  localparam int unsigned PALL_BIT    = 10;
endpackage

// File: rtl/ddr2i_bank_offset.sv
module ddr2i_bank_offset #(
  parameter int unsigned COL_W    = 2,
  parameter int unsigned ROW_W    = 2,
  parameter int unsigned POS_W    = 6,
  parameter int unsigned COL_BASE = 9,
  parameter int unsigned ROW_BASE = 11
) (
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] row,
  input  logic             interleave,
  input  logic             narrow,
  output logic [POS_W-1:0] pos
);
  logic [POS_W-1:0] row_term;
  logic [POS_W-1:0] bus_term;

  always_comb begin
    row_term = interleave ? '0 : POS_W'(row) + POS_W'(ROW_BASE);
    bus_term = narrow ? POS_W'(1) : POS_W'(2);
    pos      = POS_W'(col) + POS_W'(COL_BASE) + row_term + bus_term;
  end
endmodule

// File: rtl/ddr2i_step_table.sv
module ddr2i_step_table
  import ddr2i_pkg::*;
#(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned BA_W   = 2
) (
  input  logic [STEP_W-1:0] step,
  input  logic [ADDR_W-1:0] cfg_mr,
  input  logic [ADDR_W-1:0] cfg_emr1,
  input  logic [ADDR_W-1:0] cfg_emr2,
  output cmd_kind_e         kind,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] mr_clean;
  logic [ADDR_W-1:0] emr1_clean;

  always_comb begin
    mr_clean                       = cfg_mr;
    mr_clean[DLL_RST_BIT]          = 1'b0;
    emr1_clean                     = cfg_emr1;
    emr1_clean[DLL_DIS_BIT]        = 1'b0;
    emr1_clean[OCD_LSB +: OCD_W]   = '0;
    kind = K_NOP;
    ba   = '0;
    addr = '0;
    case (step)
      4'd0, 4'd5: begin
        kind           = K_PALL;
        addr[PALL_BIT] = 1'b1;
      end
      4'd1: begin
        kind = K_MRS;
        ba   = BA_W'(2);
        addr = cfg_emr2;
      end
      4'd2: begin
        kind = K_MRS;
        ba   = BA_W'(3);
      end
      4'd3, 4'd10: begin
        kind = K_MRS;
        ba   = BA_W'(1);
        addr = emr1_clean;
      end
      4'd4: begin
        kind              = K_MRS;
        addr              = mr_clean;
        addr[DLL_RST_BIT] = 1'b1;
      end
      4'd6, 4'd7: kind = K_REF;
      4'd8: begin
        kind = K_MRS;
        addr = mr_clean;
      end
      4'd9: begin
        kind                   = K_MRS;
        ba                     = BA_W'(1);
        addr                   = emr1_clean;
        addr[OCD_LSB +: OCD_W] = '1;
      end
      default: kind = K_NOP;
    endcase
  end
endmodule

// File: rtl/ddr2i_pin_encode.sv
module ddr2i_pin_encode
  import ddr2i_pkg::*;
(
  input  cmd_kind_e kind,
  output logic      cs_n,
  output logic      ras_n,
  output logic      cas_n,
  output logic      we_n
);
  always_comb begin
    case (kind)
      K_PALL:  {cs_n, ras_n, cas_n, we_n} = 4'b0010;
      K_MRS:   {cs_n, ras_n, cas_n, we_n} = 4'b0000;
      K_REF:   {cs_n, ras_n, cas_n, we_n} = 4'b0001;
      default: {cs_n, ras_n, cas_n, we_n} = 4'b0111;
    endcase
  end
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2i_pkg::*;
#(
  parameter int unsigned ADDR_W   = 14,
  parameter int unsigned BA_W     = 2,
  parameter int unsigned COL_W    = 2,
  parameter int unsigned ROW_W    = 2,
  parameter int unsigned POS_W    = 6,
  parameter int unsigned WAIT_CYC = 50000,
  parameter int unsigned GAP_CYC  = 4,
  parameter int unsigned RFC_CYC  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [COL_W-1:0]  cfg_col,
  input  logic [ROW_W-1:0]  cfg_row,
  input  logic              cfg_interleave,
  input  logic              cfg_narrow,
  input  logic [ADDR_W-1:0] cfg_mr,
  input  logic [ADDR_W-1:0] cfg_emr1,
  input  logic [ADDR_W-1:0] cfg_emr2,
  output logic              dram_cke,
  output logic              dram_cs_n,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic [BA_W-1:0]   dram_ba,
  output logic [ADDR_W-1:0] dram_addr,
  output logic [POS_W-1:0]  bank_bit_pos,
  output logic              busy,
  output logic              done
);
  localparam int unsigned MAX_A = (WAIT_CYC > GAP_CYC) ? WAIT_CYC : GAP_CYC;
  localparam int unsigned MAX_C = (MAX_A > RFC_CYC) ? MAX_A : RFC_CYC;
  localparam int unsigned CNT_W = $clog2(MAX_C + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_STEPS - 1);

  seq_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [STEP_W-1:0] step;
  cmd_kind_e         step_kind;
  cmd_kind_e         bus_kind;
  logic [BA_W-1:0]   step_ba;
  logic [ADDR_W-1:0] step_addr;
  logic [CNT_W-1:0]  gap_last;

  ddr2i_bank_offset #(
    .COL_W(COL_W), .ROW_W(ROW_W), .POS_W(POS_W)
  ) u_offset (
    .col(cfg_col), .row(cfg_row), .interleave(cfg_interleave),
    .narrow(cfg_narrow), .pos(bank_bit_pos)
  );

  ddr2i_step_table #(
    .ADDR_W(ADDR_W), .BA_W(BA_W)
  ) u_table (
    .step(step), .cfg_mr(cfg_mr), .cfg_emr1(cfg_emr1), .cfg_emr2(cfg_emr2),
    .kind(step_kind), .ba(step_ba), .addr(step_addr)
  );

  assign gap_last = (step_kind == K_REF) ? CNT_W'(RFC_CYC - 1) : CNT_W'(GAP_CYC - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_PWR;
      cnt   <= '0;
      step  <= '0;
    end else begin
      case (state)
        ST_PWR: begin
          if (cnt == CNT_W'(WAIT_CYC - 1)) begin
            state <= ST_CKE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_CKE: begin
          if (cnt == CNT_W'(GAP_CYC - 1)) begin
            state <= ST_CMD;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_CMD: begin
          state <= ST_GAP;
          cnt   <= '0;
        end
        ST_GAP: begin
          if (cnt == gap_last) begin
            cnt <= '0;
            if (step == LAST_STEP) state <= ST_DONE;
            else begin
              step  <= step + 1'b1;
              state <= ST_CMD;
            end
          end else cnt <= cnt + 1'b1;
        end
        ST_DONE: begin
          if (start) begin
            state <= ST_PWR;
            cnt   <= '0;
            step  <= '0;
          end
        end
        default: state <= ST_PWR;
      endcase
    end
  end

  assign bus_kind  = (state == ST_CMD) ? step_kind : K_NOP;
  assign dram_ba   = (state == ST_CMD) ? step_ba : '0;
  assign dram_addr = (state == ST_CMD) ? step_addr : '0;
  assign dram_cke  = (state != ST_PWR);
  assign done      = (state == ST_DONE);
  assign busy      = (state != ST_DONE);

  ddr2i_pin_encode u_pins (
    .kind(bus_kind), .cs_n(dram_cs_n), .ras_n(dram_ras_n),
    .cas_n(dram_cas_n), .we_n(dram_we_n)
  );
endmodule

// File: rtl/ddr2_init_seq_chk.sv
module ddr2_init_seq_chk #(
  parameter int unsigned ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              dram_cke,
  input logic              dram_cs_n,
  input logic              dram_ras_n,
  input logic              dram_cas_n,
  input logic              dram_we_n,
  input logic [ADDR_W-1:0] dram_addr,
  input logic              done
);
  logic is_nop;
  logic is_cmd;
  logic is_pall;
  assign is_nop  = !dram_cs_n && dram_ras_n && dram_cas_n && dram_we_n;
  assign is_cmd  = !dram_cs_n && !(dram_ras_n && dram_cas_n && dram_we_n);
  assign is_pall = !dram_cs_n && !dram_ras_n && dram_cas_n && !dram_we_n;

  // R1
  cke_low_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cke |-> is_nop);
  // R2
  cke_rise_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_cke) |-> is_nop);
  // R8
  cmd_then_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd |=> is_nop);
  // R4
  pall_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_pall |-> dram_addr[10]);
  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
  // R10
  cke_fall_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cke) |-> $past(done && start));
endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .dram_cke(dram_cke),
  .dram_cs_n(dram_cs_n), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
  .dram_we_n(dram_we_n), .dram_addr(dram_addr), .done(done)
);

// File: tb/tb_ddr2_init_seq.sv
module tb_ddr2_init_seq;
  localparam int AW = 14;
  localparam int WAIT = 300;
  localparam int GAP = 3;
  localparam int RFC = 9;

  typedef struct {
    logic [22:0] vec;
    string       tag;
  } exp_t;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [1:0] cfg_col = 0, cfg_row = 0;
  logic cfg_interleave = 0, cfg_narrow = 0;
  logic [AW-1:0] cfg_mr = 0, cfg_emr1 = 0, cfg_emr2 = 0;
  logic dram_cke, dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n;
  logic [1:0] dram_ba;
  logic [AW-1:0] dram_addr;
  logic [5:0] bank_bit_pos;
  logic busy, done;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  exp_t q[$];

  always #2 clk = ~clk;

  ddr2_init_seq #(.WAIT_CYC(WAIT), .GAP_CYC(GAP), .RFC_CYC(RFC)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_col(cfg_col), .cfg_row(cfg_row),
    .cfg_interleave(cfg_interleave), .cfg_narrow(cfg_narrow), .cfg_mr(cfg_mr),
    .cfg_emr1(cfg_emr1), .cfg_emr2(cfg_emr2), .dram_cke(dram_cke),
    .dram_cs_n(dram_cs_n), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_ba(dram_ba), .dram_addr(dram_addr),
    .bank_bit_pos(bank_bit_pos), .busy(busy), .done(done)
  );

  function automatic logic [22:0] pack(logic cke, logic [3:0] pins, logic [1:0] ba,
                                       logic [AW-1:0] a, logic bsy, logic dn);
    return {cke, pins, ba, a, bsy, dn};
  endfunction

  function automatic void push(logic [22:0] v, string t, int n);
    for (int i = 0; i < n; i++) q.push_back('{vec: v, tag: t});
  endfunction

  task automatic cmp(logic [22:0] exp, string tag);
    logic [22:0] act;
    act = pack(dram_cke, {dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n},
               dram_ba, dram_addr, busy, done);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s cycle=%0d actual=%h expected=%h", tag, cycles, act, exp);
    end
  endtask

  function automatic void build(int done_tail);
    logic [AW-1:0] mr0, e1;
    logic [22:0] idle;
    q.delete();
    mr0 = cfg_mr & ~(AW'(1) << 8);
    e1  = cfg_emr1 & ~AW'(14'h0381);
    idle = pack(1, 4'b0111, 0, 0, 1, 0);
    push(pack(0, 4'b0111, 0, 0, 1, 0), "R1", WAIT);
    push(idle, "R2", GAP);
    push(pack(1, 4'b0010, 0, AW'(1) << 10, 1, 0), "R3/R4 pall1", 1); push(idle, "R8", GAP);
    push(pack(1, 4'b0000, 2, cfg_emr2, 1, 0), "R3/R5 emrs2", 1);    push(idle, "R8", GAP);
    push(pack(1, 4'b0000, 3, 0, 1, 0), "R3/R5 emrs3", 1);           push(idle, "R8", GAP);
    push(pack(1, 4'b0000, 1, e1, 1, 0), "R3/R7 emrs1 dll", 1);      push(idle, "R8", GAP);
    push(pack(1, 4'b0000, 0, mr0 | (AW'(1) << 8), 1, 0), "R3/R6 mrs rst", 1); push(idle, "R8", GAP);
    push(pack(1, 4'b0010, 0, AW'(1) << 10, 1, 0), "R3/R4 pall2", 1); push(idle, "R8", GAP);
    push(pack(1, 4'b0001, 0, 0, 1, 0), "R3/R4 ref1", 1);            push(idle, "R8 rfc", RFC);
    push(pack(1, 4'b0001, 0, 0, 1, 0), "R3/R4 ref2", 1);            push(idle, "R8 rfc", RFC);
    push(pack(1, 4'b0000, 0, mr0, 1, 0), "R3/R6 mrs norst", 1);     push(idle, "R8", GAP);
    push(pack(1, 4'b0000, 1, e1 | AW'(14'h0380), 1, 0), "R3/R7 ocd dflt", 1); push(idle, "R8", GAP);
    push(pack(1, 4'b0000, 1, e1, 1, 0), "R3/R7 ocd exit", 1);       push(idle, "R8", GAP);
    push(pack(1, 4'b0111, 0, 0, 0, 1), "R9", done_tail);
  endfunction

  // Plays the expected stream; poke_at >= 0 pulses start there (R10 ignore while busy)
  task automatic play(bit via_start, int poke_at);
    if (via_start) begin
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
    end else begin
      @(negedge clk); rst_n = 1;
    end
    #1;
    for (int i = 0; i < q.size(); i++) begin
      if (i > 0) begin
        @(negedge clk); #1;
      end
      cmp(q[i].vec, q[i].tag);
      if (i == poke_at) start = 1;
      else start = 0;
    end
    start = 0;
  endtask

  always @(posedge clk) cycles++;

  initial begin
    if (cycles >= 0) begin
      wait (cycles > 150000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R11: bank bit position over all settings
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        for (int il = 0; il < 2; il++)
          for (int nw = 0; nw < 2; nw++) begin
            int e;
            cfg_col = 2'(c); cfg_row = 2'(r);
            cfg_interleave = il[0]; cfg_narrow = nw[0];
            #1;
            e = c + 9 + (il != 0 ? 0 : r + 11) + (nw != 0 ? 1 : 2);
            checks++;
            if (int'(bank_bit_pos) != e) begin
              failures++;
              $display("FAIL R11 actual=%0d expected=%0d", bank_bit_pos, e);
            end
          end
    // R1: reset state
    repeat (3) @(negedge clk);
    #1 cmp(pack(0, 4'b0111, 0, 0, 1, 0), "R1 in reset");
    // run 1: after reset, with a start pulse mid-run (R10)
    cfg_mr = 14'h0a53; cfg_emr1 = 14'h3fff; cfg_emr2 = 14'h0080;
    build(20);
    play(0, WAIT + 10);
    // run 2: restart from done (R10) with other words
    cfg_mr = 14'h3f00; cfg_emr1 = 14'h0044; cfg_emr2 = 14'h2a5a;
    build(10);
    play(1, WAIT + GAP + 2);
    // run 3: all-zero words
    cfg_mr = 0; cfg_emr1 = 0; cfg_emr2 = 0;
    build(5);
    play(1, -1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule